// File: doc/BRIEF.md
# Startup Voltage Calibration Sequencer

This block searches, once after each reset, for the lowest setpoint code at which one supply rail still lets the logic meet its performance target. When reset is released it captures an upper bound, a lower bound and a step size from its configuration inputs. It then commands the rail to the upper bound and walks the setpoint downward one step at a time. Every new setpoint goes to an external regulator-command writer through a request/acknowledge pair. Only after that write is acknowledged does the block pulse a start strobe to a test harness. The harness answers with a pass or a fail pulse.

A failed test makes the block command the last setpoint that passed, and the search ends there. A run that reaches the lower bound with every test passing ends on the lower bound. Invalid configuration sets an error flag and leaves the rail at the upper bound. At the end, a done flag and the chosen code stay frozen until the next reset. The bus that carries regulator commands and the regulator itself are outside the block.

Top module: `vmin_search`

## Requirements
- R1: The bounds and the step are captured from `cfg_hi_i`, `cfg_lo_i` and `cfg_step_i` in the first cycle after reset is released. Later changes on those inputs have no effect on the run.
- R2: Without the error condition, no code written on `cmd_code_o` is ever below the captured lower bound.
- R3: Each trial setpoint is the previous passing code minus the step, clamped to the lower bound. One test is run at each trial setpoint.
- R4: On a fail pulse, the block writes the last passing code again and then finishes, with that code as the final code.
- R5: If every trial passes down to the lower bound, the block finishes with the lower bound as the final code, without writing again.
- R6: The first write after reset carries the upper-bound code, and no test is started before it. The upper bound counts as passing without a test. If the upper bound equals the lower bound, no test is run.
- R7: `test_start_o` is asserted only after the current setpoint's write has been acknowledged, and never while `cmd_req_o` is high.
- R8: A step of zero, or a lower bound above the upper bound, raises `err_o`. The block then writes only the upper bound, runs no test, and finishes with the upper bound as the final code.
- R9: Once `done_o` is high, `done_o`, `err_o` and `final_code_o` hold until reset, and no further write or test start occurs. Pass or fail pulses received then are ignored.
- R10: `cmd_req_o` is a level that holds high, with `cmd_code_o` stable, until the cycle in which `cmd_ack_i` is sampled high. `test_start_o` is a single-cycle pulse. Pass and fail are single-cycle pulses, and fail wins if both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; a release starts one calibration |
| cfg_hi_i | input | CODE_W | Upper-bound setpoint code |
| cfg_lo_i | input | CODE_W | Lower-bound setpoint code |
| cfg_step_i | input | CODE_W | Step size in code units |
| cmd_req_o | output | 1 | Write request to the regulator-command writer |
| cmd_code_o | output | CODE_W | Setpoint code to write |
| cmd_ack_i | input | 1 | Write accepted and rail settled |
| test_start_o | output | 1 | One-cycle strobe: run a performance test |
| test_pass_i | input | 1 | Test passed pulse |
| test_fail_i | input | 1 | Test failed pulse |
| done_o | output | 1 | Calibration finished |
| err_o | output | 1 | Invalid configuration detected |
| final_code_o | output | CODE_W | Chosen setpoint, valid while done |

## Verification
The bench goes after the points where a descending search tends to slip. A first trial that fails must leave the rail back at the upper bound, and a design that does not back off would end one step too low. A step that overshoots the floor must be clamped to it, and a design without the clamp would wrap around to a huge code. Equal bounds must produce no test at all. A zero step or inverted bounds must end the run with the error flag set and the upper bound applied, and a design that misses this would hang or search below the floor. The bench also changes the configuration in the middle of a run, and sends stray pass and fail pulses after completion. A design that re-reads its inputs or restarts would then change its final code or issue extra writes.

// File: rtl/vmin_pkg.sv
package vmin_pkg;

  typedef enum logic [2:0] {
    ST_LOAD,
    ST_INIT,
    ST_WRITE,
    ST_STEP,
    ST_TEST,
    ST_WAIT,
    ST_DONE
  } state_e;

  // what to do once the pending write is acknowledged
  typedef enum logic [1:0] {
    PH_INIT,
    PH_TRY,
    PH_RESTORE,
    PH_ERR
  } phase_e;

endpackage

// File: rtl/vmin_cfg_latch.sv
module vmin_cfg_latch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         latch_i,
  input  logic [W-1:0] hi_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] step_o,
  output logic         bad_o
);

  logic [W-1:0] hi_q, lo_q, step_q;
  logic         valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= '0;
      lo_q    <= '0;
      step_q  <= '0;
      valid_q <= 1'b0;
    end else if (latch_i) begin
      hi_q    <= hi_i;
      lo_q    <= lo_i;
      step_q  <= step_i;
      valid_q <= 1'b1;
    end
  end

  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
  assign step_o = step_q;
  assign bad_o  = valid_q && ((step_q == '0) || (lo_q > hi_q));

endmodule

// File: rtl/vmin_step_calc.sv
module vmin_step_calc #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] next_o,
  output logic         at_floor_o
);

  logic [W-1:0] headroom;

  // cur_i >= lo_i whenever the configuration is valid
  assign headroom   = cur_i - lo_i;
  assign at_floor_o = (cur_i <= lo_i);
  assign next_o     = (headroom <= step_i) ? lo_i : (cur_i - step_i);

endmodule

// File: rtl/vmin_fsm.sv
module vmin_fsm
  import vmin_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] hi_i,
  input  logic         bad_i,
  input  logic [W-1:0] next_i,
  input  logic         at_floor_i,
  input  logic         cmd_ack_i,
  input  logic         test_pass_i,
  input  logic         test_fail_i,
  output logic         latch_o,
  output logic         cmd_req_o,
  output logic [W-1:0] cmd_code_o,
  output logic         test_start_o,
  output logic         done_o,
  output logic [W-1:0] pass_code_o,
  output logic [W-1:0] final_code_o
);

  state_e       state_q;
  phase_e       phase_q;
  logic [W-1:0] cmd_q, pass_q, final_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_LOAD;
      phase_q <= PH_INIT;
      cmd_q   <= '0;
      pass_q  <= '0;
      final_q <= '0;
    end else begin
      unique case (state_q)
        ST_LOAD: state_q <= ST_INIT;
        ST_INIT: begin
          cmd_q   <= hi_i;
          pass_q  <= hi_i;
          phase_q <= bad_i ? PH_ERR : PH_INIT;
          state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          if (cmd_ack_i) begin
            unique case (phase_q)
              PH_INIT: state_q <= ST_STEP;
              PH_TRY:  state_q <= ST_TEST;
              default: begin
                final_q <= pass_q;
                state_q <= ST_DONE;
              end
            endcase
          end
        end
        ST_STEP: begin
          if (at_floor_i) begin
            final_q <= pass_q;
            state_q <= ST_DONE;
          end else begin
            cmd_q   <= next_i;
            phase_q <= PH_TRY;
            state_q <= ST_WRITE;
          end
        end
        ST_TEST: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (test_fail_i) begin
            cmd_q   <= pass_q;
            phase_q <= PH_RESTORE;
            state_q <= ST_WRITE;
          end else if (test_pass_i) begin
            pass_q  <= cmd_q;
            state_q <= ST_STEP;
          end
        end
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_LOAD;
      endcase
    end
  end

  assign latch_o      = (state_q == ST_LOAD);
  assign cmd_req_o    = (state_q == ST_WRITE);
  assign cmd_code_o   = cmd_q;
  assign test_start_o = (state_q == ST_TEST);
  assign done_o       = (state_q == ST_DONE);
  assign pass_code_o  = pass_q;
  assign final_code_o = done_o ? final_q : '0;

endmodule

// File: rtl/vmin_search.sv
module vmin_search #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] cfg_hi_i,
  input  logic [CODE_W-1:0] cfg_lo_i,
  input  logic [CODE_W-1:0] cfg_step_i,
  output logic              cmd_req_o,
  output logic [CODE_W-1:0] cmd_code_o,
  input  logic              cmd_ack_i,
  output logic              test_start_o,
  input  logic              test_pass_i,
  input  logic              test_fail_i,
  output logic              done_o,
  output logic              err_o,
  output logic [CODE_W-1:0] final_code_o
);

  logic              latch;
  logic [CODE_W-1:0] hi_q, lo_q, step_q;
  logic              bad;
  logic [CODE_W-1:0] pass_code, next_code;
  logic              at_floor;

  vmin_cfg_latch #(.W(CODE_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .latch_i(latch),
    .hi_i   (cfg_hi_i),
    .lo_i   (cfg_lo_i),
    .step_i (cfg_step_i),
    .hi_o   (hi_q),
    .lo_o   (lo_q),
    .step_o (step_q),
    .bad_o  (bad)
  );

  vmin_step_calc #(.W(CODE_W)) u_step (
    .cur_i     (pass_code),
    .lo_i      (lo_q),
    .step_i    (step_q),
    .next_o    (next_code),
    .at_floor_o(at_floor)
  );

  vmin_fsm #(.W(CODE_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hi_i        (hi_q),
    .bad_i       (bad),
    .next_i      (next_code),
    .at_floor_i  (at_floor),
    .cmd_ack_i   (cmd_ack_i),
    .test_pass_i (test_pass_i),
    .test_fail_i (test_fail_i),
    .latch_o     (latch),
    .cmd_req_o   (cmd_req_o),
    .cmd_code_o  (cmd_code_o),
    .test_start_o(test_start_o),
    .done_o      (done_o),
    .pass_code_o (pass_code),
    .final_code_o(final_code_o)
  );

  assign err_o = bad;

endmodule

// File: rtl/vmin_search_chk.sv
module vmin_search_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cmd_req_i,
  input logic [W-1:0] cmd_code_i,
  input logic         cmd_ack_i,
  input logic         test_start_i,
  input logic         done_i,
  input logic         err_i,
  input logic [W-1:0] final_code_i,
  input logic [W-1:0] lo_i
);

  assert_start_after_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_start_i |-> !cmd_req_i);

  assert_req_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_i && !cmd_ack_i) |=> (cmd_req_i && $stable(cmd_code_i)));

  assert_start_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_start_i |=> !test_start_i);

  assert_floor_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_i && !err_i) |-> (cmd_code_i >= lo_i));

  assert_done_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (done_i && $stable(final_code_i) && $stable(err_i)));

  assert_done_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (!cmd_req_i && !test_start_i));

  assert_err_no_test_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !test_start_i);

endmodule

bind vmin_search vmin_search_chk #(.W(CODE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_req_i   (cmd_req_o),
  .cmd_code_i  (cmd_code_o),
  .cmd_ack_i   (cmd_ack_i),
  .test_start_i(test_start_o),
  .done_i      (done_o),
  .err_i       (err_o),
  .final_code_i(final_code_o),
  .lo_i        (lo_q)
);

// File: tb/test_vmin_search.sv
`timescale 1ns/1ps
module test_vmin_search;

  localparam int W       = 8;
  localparam int ACK_DLY = 2;
  localparam int TST_DLY = 3;
  localparam int NVEC    = 8;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
    logic [7:0] step;
    logic [7:0] thr;
  } vec_t;

  // thr: the harness passes a test when the written code is >= thr
  localparam vec_t VECS [NVEC] = '{
    '{8'd200, 8'd100, 8'd10,  8'd150},
    '{8'd200, 8'd100, 8'd30,  8'd0},
    '{8'd100, 8'd100, 8'd5,   8'd0},
    '{8'd50,  8'd60,  8'd5,   8'd0},
    '{8'd50,  8'd10,  8'd0,   8'd0},
    '{8'd200, 8'd100, 8'd10,  8'd250},
    '{8'd255, 8'd0,   8'd255, 8'd0},
    '{8'd255, 8'd3,   8'd100, 8'd50}
  };

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] cfg_hi = '0, cfg_lo = '0, cfg_step = '0;
  logic         cmd_req, cmd_ack = 1'b0;
  logic [W-1:0] cmd_code;
  logic         test_start, test_pass = 1'b0, test_fail = 1'b0;
  logic         done, err;
  logic [W-1:0] final_code;

  int n_checks = 0, n_fail = 0;
  int n_wr, last_wr, first_wr, min_wr, n_test, bad_start, drop_err;
  int thr = 0;
  bit harness_on = 1'b1;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vmin_search #(.CODE_W(W)) i_vmin_search (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_hi_i(cfg_hi), .cfg_lo_i(cfg_lo), .cfg_step_i(cfg_step),
    .cmd_req_o(cmd_req), .cmd_code_o(cmd_code), .cmd_ack_i(cmd_ack),
    .test_start_o(test_start), .test_pass_i(test_pass), .test_fail_i(test_fail),
    .done_o(done), .err_o(err), .final_code_o(final_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // regulator-command writer: ack ACK_DLY cycles after the request is seen
  initial begin
    int dly = 0;
    bit prev_req = 1'b0;
    forever begin
      @(negedge clk);
      if (prev_req && !cmd_req && dly != 0) drop_err++;
      if (cmd_req && !cmd_ack) begin
        if (dly == ACK_DLY) begin
          cmd_ack = 1'b1;
          if (n_wr == 0) first_wr = int'(cmd_code);
          n_wr++;
          last_wr = int'(cmd_code);
          if (int'(cmd_code) < min_wr) min_wr = int'(cmd_code);
          dly = 0;
        end else dly++;
      end else begin
        cmd_ack = 1'b0;
      end
      prev_req = cmd_req;
    end
  end

  // test harness: answers TST_DLY cycles after the start strobe
  initial begin
    int tc = 0;
    bit pend = 1'b0;
    forever begin
      @(negedge clk);
      if (harness_on) begin
        test_pass = 1'b0;
        test_fail = 1'b0;
        if (test_start) begin
          n_test++;
          if (cmd_req || n_wr == 0) bad_start++;
          pend = 1'b1;
          tc = 0;
        end else if (pend) begin
          tc++;
          if (tc == TST_DLY) begin
            if (last_wr >= thr) test_pass = 1'b1;
            else test_fail = 1'b1;
            pend = 1'b0;
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  // reference model of the search from the requirements
  task automatic model(input int hi, input int lo, input int step, input int th,
                       output int fin, output int e, output int w, output int t);
    int c, n;
    e = (step == 0 || lo > hi) ? 1 : 0;
    fin = hi; w = 1; t = 0;
    if (e == 0) begin
      c = hi;
      while (c > lo) begin
        n = (c - lo <= step) ? lo : c - step;
        w++; t++;
        if (n >= th) c = n;
        else begin w++; break; end
      end
      fin = c;
    end
  endtask

  task automatic start_run(input vec_t v);
    @(negedge clk);
    rst_ni = 1'b0;
    cfg_hi = v.hi; cfg_lo = v.lo; cfg_step = v.step;
    thr = int'(v.thr);
    repeat (3) @(negedge clk);
    check(!done && !cmd_req && !test_start && !err, "R9 reset state",
          {done, cmd_req, test_start, err}, 0);
    n_wr = 0; last_wr = -1; first_wr = -1; min_wr = 1000;
    n_test = 0; bad_start = 0; drop_err = 0;
    rst_ni = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    check(done, "R9 done reached", done, 1);
  endtask

  task automatic verify(input vec_t v);
    int fin, e, w, t;
    string rq;
    model(int'(v.hi), int'(v.lo), int'(v.step), int'(v.thr), fin, e, w, t);
    rq = (e != 0) ? "R8 final" : ((w > t + 1) ? "R4 final" : "R5 final");
    check(int'(err) == e, "R8 err flag", int'(err), e);
    check(int'(final_code) == fin, rq, int'(final_code), fin);
    check(last_wr == fin, "R4 rail left at final", last_wr, fin);
    check(n_wr == w, "R3 write count", n_wr, w);
    check(n_test == t, "R3 test count", n_test, t);
    check(first_wr == int'(v.hi), "R6 first write", first_wr, int'(v.hi));
    if (e == 0) check(min_wr >= int'(v.lo), "R2 floor", min_wr, int'(v.lo));
    check(bad_start == 0, "R7 start before ack", bad_start, 0);
    check(drop_err == 0, "R10 request dropped", drop_err, 0);
  endtask

  initial begin
    int hold_wr, hold_fin;
    vec_t dv;
    for (int k = 0; k < NVEC; k++) begin
      start_run(VECS[k]);
      wait_done();
      verify(VECS[k]);
    end

    // R1: configuration changes mid-run are ignored
    start_run(VECS[0]);
    repeat (4) @(negedge clk);
    cfg_hi = 8'd20; cfg_lo = 8'd90; cfg_step = 8'd0;
    wait_done();
    check(int'(final_code) == 150, "R1 cfg ignored final", int'(final_code), 150);
    check(!err, "R1 cfg ignored err", int'(err), 0);

    // R9: stray pass/fail after done are ignored, nothing restarts
    dv = '{8'd200, 8'd100, 8'd10, 8'd250};
    start_run(dv);
    wait_done();
    hold_wr = n_wr;
    hold_fin = int'(final_code);
    harness_on = 1'b0;
    @(negedge clk); test_pass = 1'b1;
    @(negedge clk); test_pass = 1'b0; test_fail = 1'b1;
    @(negedge clk); test_fail = 1'b0; test_pass = 1'b1; test_fail = 1'b1;
    @(negedge clk); test_pass = 1'b0; test_fail = 1'b0;
    repeat (20) @(negedge clk);
    harness_on = 1'b1;
    check(done, "R9 done held", done, 1);
    check(int'(final_code) == hold_fin && hold_fin == 200, "R9 final held",
          int'(final_code), 200);
    check(n_wr == hold_wr, "R9 no new writes", n_wr, hold_wr);
    check(!cmd_req && !test_start, "R9 quiet", {cmd_req, test_start}, 0);

    summary();
  end

endmodule